// File: doc/BRIEF.md
# Link-Side Packet Transmit Sequencer

This block is the link-side half of a PHY-link handover on a serial bus. It watches the 2-bit control bus coming from the PHY. When the PHY grants the bus and then drives one idle cycle, the block waits one turnaround clock and takes ownership of the control and data lines.

Once it owns the bus, it can drive one leading idle cycle and a programmable run of hold cycles, capped at 47. It then transmits a speed code followed by the bytes of a packet, which it pulls one per cycle from a show-ahead byte source. A packet whose last byte is flagged "more follows" is chained after a single hold cycle. When chaining is done with multispeed enabled, that hold cycle carries the next packet's speed code. After the final packet the block drives two idle cycles and returns its outputs to high impedance.

The bidirectional lines are split into separate input, output and output-enable signals; pad logic outside the block merges them. The reset `rst_n` is asynchronous when asserted and must be released synchronously to `clk`. The configuration inputs `lead_idle`, `hold_req` and `msc_en` must be held stable during a bus ownership.

Top module: `link_tx_seq`

## Requirements
- R1: While in reset and after reset, `ctl_oe`, `d_oe` and `pkt_rd` are 0.
- R2: When the block is off the bus and samples `ctl_i` = 11 (grant), and the next cycle samples `ctl_i` = 00, it keeps `ctl_oe` low in the two cycles after the grant cycle and starts driving in the third.
- R3: If the cycle after a grant does not carry `ctl_i` = 00, the block stays off the bus and goes back to waiting for a grant.
- R4: With `lead_idle` = 1, the first driven cycle is exactly one cycle of CTL = 00 with D = 0. With `lead_idle` = 0 there is no such cycle.
- R5: Before the first transmit, the block drives min(`hold_req`, 47) cycles of CTL = 01 (hold) with D = 0. It never drives more than 47 hold cycles in a row.
- R6: The first transmit cycle of each packet drives CTL = 10 with D = {speed, 6'b0} and `pkt_rd` = 0. Each following cycle drives CTL = 10, D = `pkt_byte` and `pkt_rd` = 1, up to and including the byte flagged with `pkt_last`.
- R7: A last byte with `pkt_more` = 1 is followed by exactly one hold cycle, then by the next packet as in R6.
- R8: With `msc_en` = 0, the gap hold cycle drives D = 0, and every chained packet carries the first packet's speed code whatever `pkt_spd` shows.
- R9: With `msc_en` = 1, the gap hold cycle drives D = {`pkt_spd`, 6'b0}, and the next packet's speed cycle repeats that same code.
- R10: A last byte with `pkt_more` = 0 is followed by two cycles of CTL = 00 with the outputs enabled, then by `ctl_oe` = `d_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY system clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ctl_i | input | 2 | Control lines as sampled from the PHY |
| ctl_o | output | 2 | Control value driven by the link |
| ctl_oe | output | 1 | Output enable for the control lines |
| d_o | output | DATA_W | Data value driven by the link |
| d_oe | output | 1 | Output enable for the data lines |
| lead_idle | input | 1 | Insert one idle cycle after taking the bus |
| hold_req | input | HREQ_W | Requested number of hold cycles before the first transmit |
| msc_en | input | 1 | Allow a different speed code per chained packet |
| pkt_byte | input | DATA_W | Current byte at the head of the packet source |
| pkt_last | input | 1 | Current byte is the last one of its packet |
| pkt_more | input | 1 | With pkt_last: another packet follows in this ownership |
| pkt_spd | input | SPD_W | Speed code of the packet at the head of the source |
| pkt_rd | output | 1 | Pops the current byte from the source |

## Verification
The bench targets the turnaround slot after the grant. A design that drives one cycle early there would collide with the PHY. It also targets the aborted handover, where the PHY does not follow grant with idle; a wrong design would take the bus anyway. Hold requests of 0, exactly 47 and above 47 expose an off-by-one or a missing clamp as a wrong number of hold cycles. Chained packets with changing speeds, run with multispeed both on and off, catch a gap hold that leaks a speed code, a speed that is not locked, or a speed cycle that pops a byte. A single-byte packet and the two-cycle release check the end-of-packet decode, where a slip shows up as a missing or extra idle cycle.

// File: rtl/lts_pkg.sv
package lts_pkg;

  // Control-line codes; link drives idle/hold/xmit, PHY drives grant.
  typedef enum logic [1:0] {
    CTL_IDLE  = 2'b00,
    CTL_HOLD  = 2'b01,
    CTL_XMIT  = 2'b10,
    CTL_GRANT = 2'b11
  } ctl_code_t;

  typedef enum logic [3:0] {
    ST_OFF       = 4'd0,
    ST_PHY_IDLE  = 4'd1,
    ST_TURN      = 4'd2,
    ST_LEAD_IDLE = 4'd3,
    ST_HOLD      = 4'd4,
    ST_SPEED     = 4'd5,
    ST_DATA      = 4'd6,
    ST_GAP_HOLD  = 4'd7,
    ST_REL0      = 4'd8,
    ST_REL1      = 4'd9
  } seq_state_t;

endpackage

// File: rtl/lts_hold_ctr.sv
module lts_hold_ctr #(
  parameter int MAX_HOLD = 47,
  parameter int REQ_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             dec_i,
  input  logic [REQ_W-1:0] req_i,
  output logic             nz_o,
  output logic             one_o
);

  localparam int CNT_W = $clog2(MAX_HOLD + 1);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_HOLD);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Load the clamped request, or count down while holding.
  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      if (req_i > REQ_W'(MAX_HOLD)) cnt_d = CAP;
      else                          cnt_d = CNT_W'(req_i);
    end else if (dec_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  assign cnt_en = load_i | dec_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign nz_o  = (cnt_q != '0);
  assign one_o = (cnt_q == CNT_W'(1));

  AST_HOLD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CAP); // R5

  AST_HOLD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i && nz_o) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R5

endmodule

// File: rtl/lts_seq_fsm.sv
module lts_seq_fsm
  import lts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ctl_i,
  input  logic       lead_idle_i,
  input  logic       hold_req_nz_i,
  input  logic       hold_nz_i,
  input  logic       hold_one_i,
  input  logic       pkt_last_i,
  input  logic       pkt_more_i,
  output seq_state_t state_o
);

  seq_state_t state_q;
  seq_state_t state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:       if (ctl_i == CTL_GRANT) state_d = ST_PHY_IDLE;
      ST_PHY_IDLE:  state_d = (ctl_i == CTL_IDLE) ? ST_TURN : ST_OFF;
      ST_TURN: begin
        if (lead_idle_i)        state_d = ST_LEAD_IDLE;
        else if (hold_req_nz_i) state_d = ST_HOLD;
        else                    state_d = ST_SPEED;
      end
      ST_LEAD_IDLE: state_d = hold_nz_i ? ST_HOLD : ST_SPEED;
      ST_HOLD:      if (hold_one_i || !hold_nz_i) state_d = ST_SPEED;
      ST_SPEED:     state_d = ST_DATA;
      ST_DATA:      if (pkt_last_i) state_d = pkt_more_i ? ST_GAP_HOLD : ST_REL0;
      ST_GAP_HOLD:  state_d = ST_SPEED;
      ST_REL0:      state_d = ST_REL1;
      ST_REL1:      state_d = ST_OFF;
      default:      state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  AST_SPEED_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SPEED) |=> (state_q == ST_DATA)); // R6

  AST_REL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REL0) |=> (state_q == ST_REL1) ##1 (state_q == ST_OFF)); // R10

endmodule

// File: rtl/lts_drive.sv
module lts_drive
  import lts_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SPD_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_t        state_i,
  input  logic              msc_en_i,
  input  logic [SPD_W-1:0]  pkt_spd_i,
  input  logic [DATA_W-1:0] pkt_byte_i,
  output logic [1:0]        ctl_o,
  output logic              bus_oe_o,
  output logic [DATA_W-1:0] d_o,
  output logic              pkt_rd_o
);

  localparam int PAD_W = DATA_W - SPD_W;

  logic [SPD_W-1:0] spd_q;
  logic [SPD_W-1:0] spd_d;
  logic             spd_en;

  // Speed is captured during turnaround and, with multispeed, at each gap.
  always_comb begin
    spd_en = 1'b0;
    spd_d  = spd_q;
    if (state_i == ST_TURN) begin
      spd_en = 1'b1;
      spd_d  = pkt_spd_i;
    end else if ((state_i == ST_GAP_HOLD) && msc_en_i) begin
      spd_en = 1'b1;
      spd_d  = pkt_spd_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      spd_q <= '0;
    else if (spd_en) spd_q <= spd_d;
  end

  always_comb begin
    ctl_o    = CTL_IDLE;
    bus_oe_o = 1'b0;
    d_o      = '0;
    pkt_rd_o = 1'b0;
    unique case (state_i)
      ST_LEAD_IDLE, ST_REL0, ST_REL1: begin
        bus_oe_o = 1'b1;
      end
      ST_HOLD: begin
        bus_oe_o = 1'b1;
        ctl_o    = CTL_HOLD;
      end
      ST_GAP_HOLD: begin
        bus_oe_o = 1'b1;
        ctl_o    = CTL_HOLD;
        if (msc_en_i) d_o = {pkt_spd_i, {PAD_W{1'b0}}};
      end
      ST_SPEED: begin
        bus_oe_o = 1'b1;
        ctl_o    = CTL_XMIT;
        d_o      = {spd_q, {PAD_W{1'b0}}};
      end
      ST_DATA: begin
        bus_oe_o = 1'b1;
        ctl_o    = CTL_XMIT;
        d_o      = pkt_byte_i;
        pkt_rd_o = 1'b1;
      end
      default: begin
        bus_oe_o = 1'b0;
      end
    endcase
  end

  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!msc_en_i && bus_oe_o && (ctl_o == CTL_HOLD)) |-> (d_o == '0)); // R8

  AST_SPEED_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!msc_en_i && (state_i == ST_GAP_HOLD)) |=> (spd_q == $past(spd_q))); // R8

endmodule

// File: rtl/link_tx_seq.sv
module link_tx_seq
  import lts_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SPD_W    = 2,
  parameter int MAX_HOLD = 47,
  parameter int HREQ_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ctl_i,
  output logic [1:0]        ctl_o,
  output logic              ctl_oe,
  output logic [DATA_W-1:0] d_o,
  output logic              d_oe,
  input  logic              lead_idle,
  input  logic [HREQ_W-1:0] hold_req,
  input  logic              msc_en,
  input  logic [DATA_W-1:0] pkt_byte,
  input  logic              pkt_last,
  input  logic              pkt_more,
  input  logic [SPD_W-1:0]  pkt_spd,
  output logic              pkt_rd
);

  localparam int RUN_W = $clog2(MAX_HOLD + 2) + 1;

  seq_state_t state;
  logic       hold_nz;
  logic       hold_one;
  logic       bus_oe;

  lts_seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_i         (ctl_i),
    .lead_idle_i   (lead_idle),
    .hold_req_nz_i (|hold_req),
    .hold_nz_i     (hold_nz),
    .hold_one_i    (hold_one),
    .pkt_last_i    (pkt_last),
    .pkt_more_i    (pkt_more),
    .state_o       (state)
  );

  lts_hold_ctr #(
    .MAX_HOLD (MAX_HOLD),
    .REQ_W    (HREQ_W)
  ) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (state == ST_TURN),
    .dec_i  (state == ST_HOLD),
    .req_i  (hold_req),
    .nz_o   (hold_nz),
    .one_o  (hold_one)
  );

  lts_drive #(
    .DATA_W (DATA_W),
    .SPD_W  (SPD_W)
  ) u_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_i    (state),
    .msc_en_i   (msc_en),
    .pkt_spd_i  (pkt_spd),
    .pkt_byte_i (pkt_byte),
    .ctl_o      (ctl_o),
    .bus_oe_o   (bus_oe),
    .d_o        (d_o),
    .pkt_rd_o   (pkt_rd)
  );

  assign ctl_oe = bus_oe;
  assign d_oe   = bus_oe;

  // Run length of consecutive driven hold cycles, for checking only.
  logic [RUN_W-1:0] hold_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              hold_run_q <= '0;
    else if (ctl_oe && (ctl_o == CTL_HOLD))  hold_run_q <= hold_run_q + RUN_W'(1);
    else                                     hold_run_q <= '0;
  end

  AST_HOLD_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    hold_run_q <= RUN_W'(MAX_HOLD)); // R5

  AST_TURN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_OFF) && (ctl_i == CTL_GRANT)) |=> !ctl_oe ##1 !ctl_oe); // R2

  AST_ABORT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_PHY_IDLE) && (ctl_i != CTL_IDLE)) |=> !ctl_oe ##1 !ctl_oe); // R3

  AST_LEAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_TURN) && lead_idle) |=> (ctl_oe && (ctl_o == CTL_IDLE)) ##1 (ctl_o != CTL_IDLE)); // R4

  AST_SPEED_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe && (ctl_o == CTL_XMIT) && !$past(ctl_oe && (ctl_o == CTL_XMIT))) |-> !pkt_rd); // R6

  AST_CHAIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_rd && pkt_last && pkt_more) |=> (ctl_oe && (ctl_o == CTL_HOLD))
      ##1 (ctl_oe && (ctl_o == CTL_XMIT) && !pkt_rd)); // R7

  AST_MSC_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (msc_en && (state == ST_GAP_HOLD)) |=> (d_o == $past(d_o))); // R9

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_rd && pkt_last && !pkt_more) |=> (ctl_oe && (ctl_o == CTL_IDLE))
      ##1 (ctl_oe && (ctl_o == CTL_IDLE)) ##1 (!ctl_oe && !d_oe)); // R10

endmodule

// File: tb/link_tx_seq_tb.sv
module link_tx_seq_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] ctl_i;
  logic [1:0] ctl_o;
  logic       ctl_oe;
  logic [7:0] d_o;
  logic       d_oe;
  logic       lead_idle;
  logic [5:0] hold_req;
  logic       msc_en;
  logic [7:0] pkt_byte;
  logic       pkt_last;
  logic       pkt_more;
  logic [1:0] pkt_spd;
  logic       pkt_rd;

  always #(CLK_PERIOD / 2) clk = ~clk;

  link_tx_seq u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_i     (ctl_i),
    .ctl_o     (ctl_o),
    .ctl_oe    (ctl_oe),
    .d_o       (d_o),
    .d_oe      (d_oe),
    .lead_idle (lead_idle),
    .hold_req  (hold_req),
    .msc_en    (msc_en),
    .pkt_byte  (pkt_byte),
    .pkt_last  (pkt_last),
    .pkt_more  (pkt_more),
    .pkt_spd   (pkt_spd),
    .pkt_rd    (pkt_rd)
  );

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  // Host byte source: show-ahead, popped by pkt_rd.
  logic [7:0] bmem [64];
  bit         blast[64];
  int         bpkt [64];
  logic [1:0] pk_spd[4];
  int         pk_len[4];
  int         npk;
  int         ptr = 0;
  logic       host_clr;

  always_ff @(posedge clk) begin
    if (host_clr)    ptr <= 0;
    else if (pkt_rd) ptr <= ptr + 1;
  end

  always_comb begin
    pkt_byte = bmem[ptr & 63];
    pkt_last = blast[ptr & 63];
    pkt_spd  = pk_spd[bpkt[ptr & 63] & 3];
    pkt_more = blast[ptr & 63] && (bpkt[ptr & 63] < npk - 1);
  end

  // Expected per-cycle trace, index 0 = grant cycle.
  bit         e_oe [256];
  logic [1:0] e_ctl[256];
  logic [7:0] e_d  [256];
  bit         e_rd [256];
  string      e_tag[256];
  int         elen;

  task automatic push(input bit oe, input logic [1:0] ctl, input logic [7:0] d,
                      input bit rd, input string tag);
    e_oe[elen] = oe; e_ctl[elen] = ctl; e_d[elen] = d; e_rd[elen] = rd; e_tag[elen] = tag;
    elen++;
  endtask

  task automatic fill_host();
    int b = 0;
    for (int i = 0; i < 64; i++) begin
      bmem[i] = '0; blast[i] = 1'b0; bpkt[i] = 3;
    end
    for (int k = 0; k < npk; k++) begin
      for (int j = 0; j < pk_len[k]; j++) begin
        bmem[b]  = 8'($urandom);
        blast[b] = (j == pk_len[k] - 1);
        bpkt[b]  = k;
        b++;
      end
    end
  endtask

  task automatic build_exp(input bit pre, input int hreq, input bit msc);
    int b = 0;
    int h;
    logic [1:0] s;
    elen = 0;
    push(1'b0, 2'b00, 8'h00, 1'b0, "R2");
    push(1'b0, 2'b00, 8'h00, 1'b0, "R2");
    push(1'b0, 2'b00, 8'h00, 1'b0, "R2");
    if (pre) push(1'b1, 2'b00, 8'h00, 1'b0, "R4");
    h = (hreq > 47) ? 47 : hreq;
    for (int i = 0; i < h; i++) push(1'b1, 2'b01, 8'h00, 1'b0, "R5");
    for (int k = 0; k < npk; k++) begin
      s = msc ? pk_spd[k] : pk_spd[0];
      push(1'b1, 2'b10, {s, 6'b0}, 1'b0, (k == 0) ? "R6" : (msc ? "R9" : "R8"));
      for (int j = 0; j < pk_len[k]; j++) begin
        push(1'b1, 2'b10, bmem[b], 1'b1, "R6");
        b++;
      end
      if (k < npk - 1)
        push(1'b1, 2'b01, msc ? {pk_spd[k+1], 6'b0} : 8'h00, 1'b0, msc ? "R7/R9" : "R7/R8");
    end
    push(1'b1, 2'b00, 8'h00, 1'b0, "R10");
    push(1'b1, 2'b00, 8'h00, 1'b0, "R10");
    push(1'b0, 2'b00, 8'h00, 1'b0, "R10");
  endtask

  task automatic check_cycle(input int c);
    checks++;
    if ((ctl_oe !== e_oe[c]) || (d_oe !== e_oe[c]) || (ctl_o !== e_ctl[c]) ||
        (d_o !== e_d[c]) || (pkt_rd !== e_rd[c])) begin
      failures++;
      $display("FAIL %s cycle %0d: got oe=%0b/%0b ctl=%b d=%h rd=%0b, expected oe=%0b ctl=%b d=%h rd=%0b",
               e_tag[c], c, ctl_oe, d_oe, ctl_o, d_o, pkt_rd,
               e_oe[c], e_ctl[c], e_d[c], e_rd[c]);
    end
  endtask

  task automatic run_grant(input bit pre, input int hreq, input bit msc);
    lead_idle = pre;
    hold_req  = 6'(hreq);
    msc_en    = msc;
    fill_host();
    build_exp(pre, hreq, msc);
    @(negedge clk);
    host_clr = 1'b1;
    @(negedge clk);
    host_clr = 1'b0;
    ctl_i    = 2'b11;
    for (int c = 1; c < elen; c++) begin
      @(negedge clk);
      if (c == 1) ctl_i = 2'b00;
      check_cycle(c);
    end
  endtask

  task automatic run_abort();
    @(negedge clk);
    ctl_i = 2'b11;
    @(negedge clk);
    ctl_i = 2'b01;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      ctl_i = 2'b00;
      checks++;
      if (ctl_oe !== 1'b0 || d_oe !== 1'b0 || pkt_rd !== 1'b0) begin
        failures++;
        $display("FAIL R3 abort cycle %0d: got oe=%0b/%0b rd=%0b, expected 0/0 rd=0",
                 c, ctl_oe, d_oe, pkt_rd);
      end
    end
  endtask

  task automatic set_pkts(input int n, input int l0, input int l1, input int l2,
                          input logic [1:0] s0, input logic [1:0] s1, input logic [1:0] s2);
    npk = n;
    pk_len[0] = l0; pk_len[1] = l1; pk_len[2] = l2; pk_len[3] = 0;
    pk_spd[0] = s0; pk_spd[1] = s1; pk_spd[2] = s2; pk_spd[3] = 2'b00;
  endtask

  initial begin
    void'($urandom(32'h5EED1394));
    rst_n = 1'b0; ctl_i = 2'b00; lead_idle = 1'b0; hold_req = '0; msc_en = 1'b0;
    host_clr = 1'b1;
    set_pkts(1, 1, 0, 0, 2'b00, 2'b00, 2'b00);
    fill_host();
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    checks++;
    if (ctl_oe !== 1'b0 || d_oe !== 1'b0 || pkt_rd !== 1'b0) begin
      failures++;
      $display("FAIL R1 in reset: got oe=%0b/%0b rd=%0b, expected 0/0 rd=0", ctl_oe, d_oe, pkt_rd);
    end
    rst_n = 1'b1;
    host_clr = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if (ctl_oe !== 1'b0 || d_oe !== 1'b0 || pkt_rd !== 1'b0) begin
      failures++;
      $display("FAIL R1 after reset: got oe=%0b/%0b rd=%0b, expected 0/0 rd=0", ctl_oe, d_oe, pkt_rd);
    end

    // Directed corners
    set_pkts(1, 1, 0, 0, 2'b01, 2'b00, 2'b00);
    run_grant(1'b0, 0, 1'b0);                 // R2 R6 R10 minimal
    set_pkts(2, 3, 2, 0, 2'b10, 2'b01, 2'b00);
    run_grant(1'b1, 47, 1'b0);                // R4 R5 exact cap, R7 R8
    set_pkts(1, 4, 0, 0, 2'b11, 2'b00, 2'b00);
    run_grant(1'b0, 63, 1'b0);                // R5 clamp
    run_abort();                              // R3
    set_pkts(3, 2, 1, 5, 2'b00, 2'b11, 2'b01);
    run_grant(1'b1, 3, 1'b1);                 // R9 speeds change
    set_pkts(3, 1, 1, 1, 2'b01, 2'b10, 2'b11);
    run_grant(1'b0, 1, 1'b0);                 // R8 speeds locked

    // Random mix
    for (int t = 0; t < 24; t++) begin
      int n;
      n = 1 + int'($urandom % 3);
      set_pkts(n, 1 + int'($urandom % 8), 1 + int'($urandom % 8), 1 + int'($urandom % 8),
               2'($urandom), 2'($urandom), 2'($urandom));
      run_grant(1'($urandom), int'($urandom % 64), 1'($urandom));
      if (($urandom % 4) == 0) run_abort();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule